// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a parameterised chain of shift register latch cells for scan testing of latch-based logic. Each cell holds two level-sensitive latches. The first latch has two ports. The system clock makes it transparent to the cell's functional data bit, and the shift clock makes it transparent to the cell's scan input. The transfer clock makes the second latch transparent to the first. The second latch of each cell feeds the scan input of the next cell. The second latch of the last cell drives the serial output.

The three clocks are pulsed one at a time, and at most one of them is high at any moment. This spacing is what keeps the chain free of races. The block has four operating phases:
- **Idle**: all clocks are low and both latches hold.
- **Load**: the system clock is high.
- **Shift**: the shift clock is high.
- **Transfer**: the transfer clock is high.

A capture is a Load pulse followed by a Transfer pulse. One shift step is a Shift pulse followed by a Transfer pulse. A parameter chooses whether the functional outputs are tapped from the first latch or from the second latch of each cell.

Top module: `lssd_chain`

## Requirements
- R1: While `ck_sys` is high, bit i of `l1_q` follows bit i of `sys_d`.
- R2: While `ck_shift` is high, the first latch of cell 0 follows `scan_in`, and the first latch of cell i (i > 0) follows the second latch of cell i-1.
- R3: While `ck_xfer` is high, bit i of `l2_q` follows bit i of `l1_q`.
- R4: While all three clocks are low, `l1_q` and `l2_q` hold their values. Changes on `sys_d` and `scan_in` have no effect on them.
- R5: A pulse on `ck_sys` alone, or on `ck_shift` alone, leaves `l2_q` unchanged.
- R6: `scan_out` always equals bit N_CELLS-1 of `l2_q`.
- R7: One shift step is a `ck_shift` pulse followed by a `ck_xfer` pulse. After N_CELLS steps in which step k presents bit k of a pattern on `scan_in`, cell N_CELLS-1-k holds bit k. Further steps then deliver the bits on `scan_out` in the order they entered, with bit 0 readable before the first further step.
- R8: A capture, which is a `ck_sys` pulse followed by a `ck_xfer` pulse, places `sys_d` on `l2_q` in every cell.
- R9: `func_q` equals `l2_q` when FUNC_TAP is TAP_L2 (the default), and equals `l1_q` when FUNC_TAP is TAP_L1.
- R10: At most one of `ck_sys`, `ck_shift` and `ck_xfer` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ck_sys | input | 1 | System clock. When high, the first latch of each cell takes its functional data bit. |
| ck_shift | input | 1 | Shift clock. When high, the first latch of each cell takes its scan input. |
| ck_xfer | input | 1 | Transfer clock. When high, the second latch of each cell takes the first latch's value. |
| sys_d | input | N_CELLS | Functional data, with one bit per cell. |
| scan_in | input | 1 | Serial scan input to cell 0. |
| scan_out | output | 1 | Serial scan output from the last cell's second latch. |
| l1_q | output | N_CELLS | First latch values, with one bit per cell. |
| l2_q | output | N_CELLS | Second latch values, with one bit per cell. |
| func_q | output | N_CELLS | Outputs to downstream logic, tapped from the latch that FUNC_TAP selects. |

## Verification
Some properties are checked on every cycle:
- the clocks never overlap;
- at the falling edge of each clock, the latch it opened holds the value of the source it was transparent to (system data, scan input, or first latch).

Other properties can only be shown by the bench's scenarios:
- the hold behaviour while all clocks are idle;
- the first-in first-out order of a full pattern shifted through and out of the chain;
- a capture followed by an unload;
- the choice of tap latch.

The bench tracks both latches in a behavioural model and compares them every cycle.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

    // Which latch of each cell drives the downstream logic.
    typedef enum logic {
        TAP_L1 = 1'b0,
        TAP_L2 = 1'b1
    } tap_e;

endpackage

// File: rtl/lssd_srl_cell.sv
module lssd_srl_cell (
    input  logic ck_sys,
    input  logic ck_shift,
    input  logic ck_xfer,
    input  logic d,
    input  logic si,
    output logic l1,
    output logic l2
);

    // First latch, with two ports. The system port has priority. That
    // priority only matters under an illegal overlap of the clocks.
    always_latch begin
        if (ck_sys) begin
            l1 <= d;
        end else if (ck_shift) begin
            l1 <= si;
        end
    end

    // Second latch, transparent to the first while the transfer clock is high.
    always_latch begin
        if (ck_xfer) begin
            l2 <= l1;
        end
    end

    // R1
    always_ff @(negedge ck_sys) begin
        if (!$isunknown({d, l1})) begin
            sys_load_chk: assert (l1 == d);
        end
    end

    // R2
    always_ff @(negedge ck_shift) begin
        if (!$isunknown({si, l1})) begin
            scan_load_chk: assert (l1 == si);
        end
    end

    // R3
    always_ff @(negedge ck_xfer) begin
        if (!$isunknown({l1, l2})) begin
            xfer_copy_chk: assert (l2 == l1);
        end
    end

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain #(
    parameter int             N_CELLS  = 8,
    parameter lssd_pkg::tap_e FUNC_TAP = lssd_pkg::TAP_L2
) (
    input  logic               ck_sys,
    input  logic               ck_shift,
    input  logic               ck_xfer,
    input  logic [N_CELLS-1:0] sys_d,
    input  logic               scan_in,
    output logic               scan_out,
    output logic [N_CELLS-1:0] l1_q,
    output logic [N_CELLS-1:0] l2_q,
    output logic [N_CELLS-1:0] func_q
);

    localparam int LAST = N_CELLS - 1;

    logic [N_CELLS-1:0] link_si;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign link_si[i] = scan_in;
        end else begin : g_body
            assign link_si[i] = l2_q[i-1];
        end

        lssd_srl_cell u_cell (
            .ck_sys   (ck_sys),
            .ck_shift (ck_shift),
            .ck_xfer  (ck_xfer),
            .d        (sys_d[i]),
            .si       (link_si[i]),
            .l1       (l1_q[i]),
            .l2       (l2_q[i])
        );
    end

    assign scan_out = l2_q[LAST];

    if (FUNC_TAP == lssd_pkg::TAP_L1) begin : g_tap_l1
        assign func_q = l1_q;
    end else begin : g_tap_l2
        assign func_q = l2_q;
    end

    // R10
    always_comb begin
        if (!$isunknown({ck_sys, ck_shift, ck_xfer})) begin
            clk_overlap_chk: assert ($countones({ck_sys, ck_shift, ck_xfer}) <= 1);
        end
    end

endmodule

// File: tb/tb_lssd_chain.sv
module tb_lssd_chain;

    localparam int N = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         ck_sys = 1'b0, ck_shift = 1'b0, ck_xfer = 1'b0;
    logic [N-1:0] sys_d = '0;
    logic         scan_in = 1'b0;
    logic         scan_out, scan_out_b;
    logic [N-1:0] l1_q, l2_q, func_q, l1_b, l2_b, func_b;

    lssd_chain #(.N_CELLS(N), .FUNC_TAP(lssd_pkg::TAP_L2)) dut (
        .ck_sys(ck_sys), .ck_shift(ck_shift), .ck_xfer(ck_xfer),
        .sys_d(sys_d), .scan_in(scan_in), .scan_out(scan_out),
        .l1_q(l1_q), .l2_q(l2_q), .func_q(func_q)
    );

    lssd_chain #(.N_CELLS(N), .FUNC_TAP(lssd_pkg::TAP_L1)) dut_tap1 (
        .ck_sys(ck_sys), .ck_shift(ck_shift), .ck_xfer(ck_xfer),
        .sys_d(sys_d), .scan_in(scan_in), .scan_out(scan_out_b),
        .l1_q(l1_b), .l2_q(l2_b), .func_q(func_b)
    );

    // Behavioural model of both latch ranks.
    logic [N-1:0] m1 = 'x, m2 = 'x;
    int    vectors = 0, errors = 0, cycles = 0;
    string tag = "R4";

    task automatic chk(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!$isunknown(m1)) begin
            chk(tag, l1_q, m1);
            chk("R9", func_b, m1);
        end
        if (!$isunknown(m2)) begin
            chk(tag, l2_q, m2);
            chk("R6", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m2[N-1]});
            chk("R9", func_q, m2);
        end
    end

    // Clock overlap monitor.
    always @(ck_sys or ck_shift or ck_xfer) begin
        if ((int'(ck_sys) + int'(ck_shift) + int'(ck_xfer)) > 1) begin
            errors++;
            $display("FAIL R10: actual %b%b%b expected at most one clock high",
                     ck_sys, ck_shift, ck_xfer);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // which: 0 = system clock, 1 = shift clock, 2 = transfer clock
    task automatic pulse(input int which);
        @(posedge clk);
        case (which)
            0: begin tag = "R1"; ck_sys = 1'b1;   m1 = sys_d; end
            1: begin tag = "R2"; ck_shift = 1'b1; m1 = {m2[N-2:0], scan_in}; end
            default: begin tag = "R3"; ck_xfer = 1'b1; m2 = m1; end
        endcase
        @(posedge clk);
        ck_sys = 1'b0; ck_shift = 1'b0; ck_xfer = 1'b0;
        tag = "R4";
        @(posedge clk);
    endtask

    task automatic shift_step(input logic b);
        @(posedge clk);
        scan_in = b;
        pulse(1);
        pulse(2);
    endtask

    initial begin
        logic [N-1:0] pat, got, prev2;

        repeat (3) @(posedge clk);

        // Known starting state through a capture of zeros (R8)
        sys_d = '0;
        pulse(0);
        pulse(2);
        @(negedge clk);
        chk("R8", l2_q, '0);

        // Load alone: L1 takes the data, L2 holds (R1, R5)
        sys_d = 8'hA5;
        pulse(0);
        @(negedge clk);
        chk("R1", l1_q, 8'hA5);
        chk("R5", l2_q, 8'h00);
        pulse(2);
        @(negedge clk);
        chk("R8", l2_q, 8'hA5);

        // Inputs change while idle: no effect (R4)
        sys_d = 8'h3C; scan_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R4", l1_q, 8'hA5);
        chk("R4", l2_q, 8'hA5);

        // Shift pulse alone: L1 shifted, L2 held (R2, R5)
        prev2 = l2_q;
        pulse(1);
        @(negedge clk);
        chk("R2", l1_q, {prev2[N-2:0], 1'b1});
        chk("R5", l2_q, prev2);
        pulse(2);
        @(negedge clk);
        chk("R3", l2_q, {prev2[N-2:0], 1'b1});

        // Full pattern in, then out first-in first-out (R7)
        pat = 8'b1101_0010;
        for (int k = 0; k < N; k++) shift_step(pat[k]);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            chk("R7", {{(N-1){1'b0}}, l2_q[N-1-k]}, {{(N-1){1'b0}}, pat[k]});
        end
        got = '0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            got[k] = scan_out;
            shift_step(1'b0);
        end
        chk("R7", got, pat);
        @(negedge clk);
        chk("R7", l2_q, '0);

        // Capture, then unload serially (R8, R6)
        sys_d = 8'h5A;
        pulse(0);
        pulse(2);
        @(negedge clk);
        chk("R8", l2_q, 8'h5A);
        got = '0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            got[N-1-k] = scan_out;
            shift_step(1'b0);
        end
        chk("R6", got, 8'h5A);

        // Tap selection at a known point (R9)
        @(negedge clk);
        chk("R9", func_q, l2_q);
        chk("R9", func_b, l1_b);

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule